// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps time of day in binary-coded decimal. A single input carries an enable pulse that arrives at the mains line rate of 60 per second. A prescaler turns those pulses into one-second steps. Two cascaded base-sixty stages count seconds and minutes. An hours stage runs through 1 to 12 and never shows zero.

All registers share one clock and step together. A carry out of the seconds stage, a minute step and an hour step that fall on the same edge all land on that edge. The digit outputs therefore never show a partial or illegal value. The hours stage has a single tens bit and a four-bit units digit. When the hours advance from 12, it clears the tens bit and loads 0001 into the units digit on the same edge.

Top module: `twelve_hour_clock`

## Requirements
- R1: After reset the outputs read 12:00:00, with the hours tens bit at 1 and the hours units at 2. The prescaler phase also restarts, so the first second step comes after PRESCALE further input pulses.
- R2: The seconds advance by one on every PRESCALE-th cycle in which tick_in is high, counting only those cycles, and on no other cycle.
- R3: Each seconds or minutes stage has a units digit that counts 0 to 9 and a tens digit that counts 0 to 5. A step from 59 gives 00. No digit ever holds a value at or above its modulus.
- R4: The minutes advance by one exactly on the edge where the seconds go from 59 to 00, and hold at every other time.
- R5: The hours advance exactly on the edge where both minutes and seconds go from 59 to 00, and hold at every other time.
- R6: When the hours advance from units 9 with the tens bit at 0, the result is tens 1 and units 0, so 09 is followed by 10.
- R7: When the hours advance from 12, the tens bit clears and the units digit loads 0001, so the next value is 01. The reload is chosen when the tens bit is 1 and the two low bits of the incremented units value would be 11.
- R8: The hours value read as tens*10+units is always between 1 and 12.
- R9: A step at 12:59:59 (and at any hh:59:59) gives the new hour together with minutes 00 and seconds 00 on one clock edge.
- R10: A cycle with tick_in low changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset to 12:00:00 |
| tick_in | input | 1 | Line-rate enable pulse, one cycle high per tick |
| sec_ones | output | 4 | Seconds units, BCD 0-9 |
| sec_tens | output | 3 | Seconds tens, 0-5 |
| min_ones | output | 4 | Minutes units, BCD 0-9 |
| min_tens | output | 3 | Minutes tens, 0-5 |
| hr_tens | output | 1 | Hours tens bit |
| hr_ones | output | 4 | Hours units, BCD 0-9 |

## Verification
The bench sets the prescaler to three and runs one complete twelve-hour cycle. It compares every cycle against a model that derives the time from an elapsed-second count by division. The sweep also passes through gaps in the tick input, which checks that a prescaler that counts clocks instead of ticks is caught.

The crossings that matter are 09 to 10, 12:59:59 to 01:00:00 and 11:59:59 to 12:00:00. A wrong reload rule would show 13 or 00 there, or would skip 10. A cascade whose carries landed on separate edges would show a stale minute or hour for one cycle. A reset applied partway through the run checks that both the time and the prescaler phase start over.

// File: rtl/clock_pkg.sv
package clock_pkg;

  typedef struct packed {
    logic       tens;
    logic [3:0] ones;
  } hour_t;

  localparam hour_t HOUR_AT_RESET = '{tens: 1'b1, ones: 4'd2};

  // next value of a digit that wraps at the given modulus
  function automatic logic [3:0] digit_step(logic [3:0] v, int unsigned modulus);
    return (32'(v) == modulus - 1) ? 4'd0 : v + 4'd1;
  endfunction

  function automatic logic digit_last(logic [3:0] v, int unsigned modulus);
    return 32'(v) == modulus - 1;
  endfunction

  // hours step: reload to 01 when the tens bit is set and the incremented units
  // would end in binary 11; a units 9 carries into the tens bit
  function automatic hour_t hour_step(hour_t h);
    logic [3:0] bumped;
    hour_t      r;
    bumped = h.ones + 4'd1;
    if (h.tens && bumped[1:0] == 2'b11) begin
      r.tens = 1'b0;
      r.ones = 4'd1;
    end else if (h.ones == 4'd9) begin
      r.tens = 1'b1;
      r.ones = 4'd0;
    end else begin
      r.tens = h.tens;
      r.ones = bumped;
    end
    return r;
  endfunction

  function automatic logic hour_legal(hour_t h);
    return (!h.tens && h.ones >= 4'd1 && h.ones <= 4'd9) ||
           ( h.tens && h.ones <= 4'd2);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRESCALE = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic sec_pulse
);

  generate
    if (PRESCALE <= 1) begin : g_pass
      assign sec_pulse = tick_in;
    end else begin : g_count
      localparam int unsigned CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] phase;

      assign sec_pulse = tick_in && (phase == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          phase <= '0;
        else if (sec_pulse)  phase <= '0;
        else if (tick_in)    phase <= phase + 1'b1;
      end

      // R2: phase stays inside the divide ratio
      p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(phase) < PRESCALE);

      // R2: phase only moves on an input tick
      p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(phase));
    end
  endgenerate

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import clock_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned MODULUS   = 10,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  localparam logic [WIDTH-1:0] RST = WIDTH'(RESET_VAL);

  logic [3:0]       q_wide;
  logic [WIDTH-1:0] q_next;

  assign q_wide = 4'(q);
  assign q_next = WIDTH'(digit_step(q_wide, MODULUS));
  assign carry  = en && digit_last(q_wide, MODULUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= q_next;
  end

  // R3: digit never reaches its modulus
  p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(q) < MODULUS);

  // R3: a carry is followed by a zero digit
  p_digit_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> q == '0);

endmodule

// File: rtl/sixty_counter.sv
module sixty_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  output logic [3:0] ones,
  output logic [2:0] tens,
  output logic       wrap
);

  logic ones_carry;

  bcd_digit #(.WIDTH(4), .MODULUS(10), .RESET_VAL(0)) u_ones (
    .clk(clk), .rst_n(rst_n), .en(step), .q(ones), .carry(ones_carry)
  );

  bcd_digit #(.WIDTH(3), .MODULUS(6), .RESET_VAL(0)) u_tens (
    .clk(clk), .rst_n(rst_n), .en(ones_carry), .q(tens), .carry(wrap)
  );

  // R3: a 59 -> 00 wrap leaves both digits at zero on the same edge
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ones == 4'd0 && tens == 3'd0));

endmodule

// File: rtl/hour_counter.sv
module hour_counter
  import clock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  output logic       tens,
  output logic [3:0] ones
);

  hour_t cur, nxt;

  assign nxt  = hour_step(cur);
  assign tens = cur.tens;
  assign ones = cur.ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= HOUR_AT_RESET;
    else if (advance) cur <= nxt;
  end

  // R8: only 1..12 is ever held
  p_hour_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hour_legal(cur));

  // R6: 09 is followed by 10
  p_nine_to_ten_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !tens && ones == 4'd9) |=> (tens && ones == 4'd0));

  // R7: 12 is followed by 01
  p_twelve_to_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && tens && ones == 4'd2) |=> (!tens && ones == 4'd1));

endmodule

// File: rtl/twelve_hour_clock.sv
module twelve_hour_clock #(
  parameter int unsigned PRESCALE = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  output logic [3:0] sec_ones,
  output logic [2:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [2:0] min_tens,
  output logic       hr_tens,
  output logic [3:0] hr_ones
);

  // internal events brought out by name
  logic sec_pulse;
  logic sec_wrap;
  logic min_wrap;

  tick_prescaler #(.PRESCALE(PRESCALE)) u_prescale (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .sec_pulse(sec_pulse)
  );

  sixty_counter u_seconds (
    .clk(clk), .rst_n(rst_n), .step(sec_pulse),
    .ones(sec_ones), .tens(sec_tens), .wrap(sec_wrap)
  );

  sixty_counter u_minutes (
    .clk(clk), .rst_n(rst_n), .step(sec_wrap),
    .ones(min_ones), .tens(min_tens), .wrap(min_wrap)
  );

  hour_counter u_hours (
    .clk(clk), .rst_n(rst_n), .advance(min_wrap),
    .tens(hr_tens), .ones(hr_ones)
  );

  // R10: no tick, no change anywhere
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> $stable({sec_tens, sec_ones, min_tens, min_ones, hr_tens, hr_ones}));

  // R2: seconds move only on a prescaler pulse
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse |=> $stable({sec_tens, sec_ones}));

  // R4: minutes move only on a seconds wrap
  p_min_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_wrap |=> $stable({min_tens, min_ones}));

  // R5: hours move only on a minutes wrap
  p_hour_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !min_wrap |=> $stable({hr_tens, hr_ones}));

  // R9: an hour step lands together with zeroed minutes and seconds
  p_single_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    min_wrap |=> (min_ones == 4'd0 && min_tens == 3'd0 &&
                  sec_ones == 4'd0 && sec_tens == 3'd0));

endmodule

// File: tb/twelve_hour_clock_bench.sv
module twelve_hour_clock_bench;

  localparam int unsigned PS        = 3;
  localparam int          DAY_SECS  = 43200;
  localparam int          WATCHDOG  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic [3:0] sec_ones, min_ones, hr_ones;
  logic [2:0] sec_tens, min_tens;
  logic       hr_tens;

  int checks = 0;
  int errors = 0;
  int secs   = 0;   // elapsed seconds since 12:00:00
  int phase  = 0;   // ticks counted toward the next second
  bit done   = 1'b0;

  always #10 clk = ~clk;

  twelve_hour_clock #(.PRESCALE(PS)) u_twelve_hour_clock (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
    .sec_ones(sec_ones), .sec_tens(sec_tens),
    .min_ones(min_ones), .min_tens(min_tens),
    .hr_tens(hr_tens), .hr_ones(hr_ones)
  );

  function automatic int disp_hour(int s);
    int h;
    h = s / 3600;
    return (h == 0) ? 12 : h;
  endfunction

  function automatic int got_time();
    return (int'(hr_tens) * 10 + int'(hr_ones)) * 10000 +
           (int'(min_tens) * 10 + int'(min_ones)) * 100 +
           (int'(sec_tens) * 10 + int'(sec_ones));
  endfunction

  function automatic int want_time(int s);
    return disp_hour(s) * 10000 + ((s / 60) % 60) * 100 + (s % 60);
  endfunction

  task automatic check(string tag, int got, int want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, want, $time);
    end
  endtask

  task automatic check_digits(string tag);
    // digit-by-digit check so a stray BCD value cannot hide in the sum
    check(tag, {28'd0, sec_ones}, (secs % 60) % 10);
    check(tag, {29'd0, sec_tens}, (secs % 60) / 10);
    check(tag, {28'd0, min_ones}, ((secs / 60) % 60) % 10);
    check(tag, {29'd0, min_tens}, ((secs / 60) % 60) / 10);
    check(tag, {28'd0, hr_ones},  disp_hour(secs) % 10);
    check(tag, {31'd0, hr_tens},  disp_hour(secs) / 10);
  endtask

  // one clock with tick_in = t; model update then compare after the edge
  task automatic step(bit t);
    int    prev_s, ph, nh;
    string tag;
    tick_in = t;
    @(posedge clk);
    @(negedge clk);
    prev_s = secs;
    if (t) begin
      phase++;
      if (phase == PS) begin
        phase = 0;
        secs  = (secs + 1) % DAY_SECS;
      end
    end
    ph = disp_hour(prev_s);
    nh = disp_hour(secs);
    if (!t)                        tag = "R10";
    else if (ph == 12 && nh == 1)  tag = "R7";
    else if (ph == 9 && nh == 10)  tag = "R6";
    else if (ph != nh)             tag = "R5";
    else if (prev_s / 60 != secs / 60) tag = "R4";
    else if (prev_s != secs)       tag = "R3";
    else                           tag = "R2";
    check(tag, got_time(), want_time(secs));
    if (ph != nh) begin
      check("R8", int'(hr_tens) * 10 + int'(hr_ones) >= 1 &&
                  int'(hr_tens) * 10 + int'(hr_ones) <= 12, 1);
      check("R9", got_time() % 10000, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_digits("R1");
    check("R1", got_time(), 120000);

    // gapped ticks: only high cycles count toward the prescaler (R2, R10)
    for (int i = 0; i < 60; i++) step((i % 4) != 1);

    // continuous run over a full twelve-hour cycle plus margin
    for (int i = 0; i < DAY_SECS * PS + 30; i++) step(1'b1);
    check_digits("R3");

    // reset in mid-run: time and prescaler phase restart (R1)
    tick_in = 1'b0;
    rst_n   = 1'b0;
    @(negedge clk);
    rst_n   = 1'b1;
    secs    = 0;
    phase   = 0;
    @(negedge clk);
    check("R1", got_time(), 120000);
    step(1'b1);
    step(1'b1);
    check("R1", got_time(), 120000);
    step(1'b1);
    check("R2", got_time(), 120001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, got %0d expected completion", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule